// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits beside a data-cache pipeline. It records every load the pipeline issues and sends each load's result to the integer register file in the order the loads were issued. For each load, the issue side supplies a tag, an access size, a signed flag, the low address bits and a hit flag. On the return side the block produces one write-back event per cycle, which is either a data return or a trap, and carries the load's tag.

A load that hits returns after a short fixed latency. A signed load narrower than a doubleword needs one extra cycle. Such a load also switches the loads issued right behind it into the slower return mode. A missed load stays at the head of the queue until the fill input reports that its data has arrived, and every younger load waits behind it. A load whose address does not match its size returns a trap and no data.

Top module: `ld_inorder_ret`

## Requirements
- R1: After reset the queue is empty, `wb_vld`, `wb_trap` and `iss_stall` are low, and the slow return mode is off.
- R2: An accepted aligned hit that is neither signed-narrow nor in slow mode produces its write-back event 2 clock edges after the issue edge, provided nothing older is still queued.
- R3: An accepted load with `iss_sgn`=1 and `iss_size` not equal to 3 is signed-narrow and returns 3 edges after issue. The size codes are 0 byte, 1 halfword, 2 word and 3 doubleword.
- R4: Slow mode is on after an edge that accepted a signed-narrow load, and it stays on across each following edge that accepts a load. An edge that accepts no load turns it off. Any load accepted while slow mode is on returns after 3 edges.
- R5: Write-back events leave in issue order. While the oldest queued load is an unfilled miss, no event is produced.
- R6: `fill_vld` marks the oldest queued load as filled only if that load is an unfilled miss, and the load then returns on the following edge once its latency has elapsed. Younger ready loads then drain at one per edge. A `fill_vld` at any other time has no effect.
- R7: A load is misaligned when its address offset is not a multiple of its size: size 1 with `iss_addr[0]` set, size 2 with `iss_addr[1:0]` nonzero, or size 3 with `iss_addr[2:0]` nonzero. A misaligned load ignores its hit flag and returns in its ordered slot with `wb_trap`=1, `wb_vld`=0 and its tag.
- R8: At most one write-back event occurs per cycle, so `wb_vld` and `wb_trap` are never high together. When neither is high, `wb_tag` is 0.
- R9: `iss_stall` is high exactly when DEPTH loads are outstanding. An issue offered while it is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | A load is issued this cycle |
| iss_tag | input | TAG_W | Destination tag of the load |
| iss_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| iss_sgn | input | 1 | Load is sign-extending |
| iss_addr | input | 3 | Low address bits, used for the alignment check |
| iss_hit | input | 1 | Load hit in the data cache |
| iss_stall | output | 1 | Queue full, issue refused |
| fill_vld | input | 1 | Fill data arrived for the oldest pending miss |
| wb_vld | output | 1 | Load data is written back this cycle |
| wb_trap | output | 1 | Misaligned load traps this cycle |
| wb_tag | output | TAG_W | Tag of the returning load |

## Verification
The bench first drives directed patterns. These include a lone unsigned hit, a lone signed byte, a run of back-to-back loads behind a signed load, and the same run broken by one idle cycle. Together they separate the 2-edge and 3-edge latencies and show where slow mode begins and ends. Further directed cases cover a miss with younger hits queued behind it, a fill offered while the head is a hit, a misaligned load marked as a miss, and enough unfilled misses to fill the queue. These show ordering, fill handling, the trap path and the stall refusal. A long seeded random mix of sizes, signs, offsets, hits and fills is then compared every cycle against a bench model that keeps the absolute return cycle of each load.

// File: rtl/ld_inorder_ret.sv
module ld_inorder_ret #(
  parameter int DEPTH   = 4,
  parameter int TAG_W   = 5,
  parameter int HIT_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic [1:0]       iss_size,
  input  logic             iss_sgn,
  input  logic [2:0]       iss_addr,
  input  logic             iss_hit,
  output logic             iss_stall,
  input  logic             fill_vld,
  output logic             wb_vld,
  output logic             wb_trap,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WT_W  = $clog2(HIT_LAT + 1);
  localparam logic [WT_W-1:0] WAIT_FAST = WT_W'(HIT_LAT - 1);
  localparam logic [WT_W-1:0] WAIT_SLOW = WT_W'(HIT_LAT);

  logic [TAG_W-1:0] q_tag  [DEPTH];
  logic [WT_W-1:0]  q_wait [DEPTH];
  logic [DEPTH-1:0] q_trap, q_miss;
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             slow_mode;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic misalign, narrow_sgn, accept, head_rdy;

  assign misalign   = (iss_size == 2'd1) ? iss_addr[0] :
                      (iss_size == 2'd2) ? |iss_addr[1:0] :
                      (iss_size == 2'd3) ? |iss_addr : 1'b0;
  assign narrow_sgn = iss_sgn && (iss_size != 2'd3);
  assign iss_stall  = (count == CNT_W'(DEPTH));
  assign accept     = iss_vld && !iss_stall;
  assign head_rdy   = (count != '0) && (q_wait[head] == '0) && !q_miss[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      slow_mode <= 1'b0;
      wb_vld    <= 1'b0;
      wb_trap   <= 1'b0;
      wb_tag    <= '0;
      q_miss    <= '0;
      q_trap    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_wait[i] <= '0;
        q_tag[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (q_wait[i] != '0) q_wait[i] <= q_wait[i] - 1'b1;
      if (fill_vld && count != '0 && q_miss[head]) q_miss[head] <= 1'b0;
      wb_vld  <= head_rdy && !q_trap[head];
      wb_trap <= head_rdy && q_trap[head];
      wb_tag  <= head_rdy ? q_tag[head] : '0;
      if (head_rdy) head <= nxt(head);
      if (accept) begin
        q_tag[tail]  <= iss_tag;
        q_trap[tail] <= misalign;
        q_miss[tail] <= !iss_hit && !misalign;
        q_wait[tail] <= (narrow_sgn || slow_mode) ? WAIT_SLOW : WAIT_FAST;
        tail         <= nxt(tail);
      end
      count     <= count + CNT_W'(accept) - CNT_W'(head_rdy);
      slow_mode <= accept && (narrow_sgn || slow_mode);
    end
  end

  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_vld && wb_trap));

  p_miss_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && q_miss[head]) |=> (!wb_vld && !wb_trap));

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (!wb_vld && !wb_trap));

  p_stall_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && iss_stall) |=> (count <= $past(count)));

  p_fill_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && count != '0 && q_miss[head] && q_wait[head] <= WT_W'(1))
      |-> ##2 wb_vld);
endmodule

// File: tb/ld_inorder_ret_bench.sv
module ld_inorder_ret_bench;
  localparam int DEPTH = 4;
  localparam int TAG_W = 5;

  logic clk = 0, rst_n = 0;
  logic iss_vld = 0, iss_sgn = 0, iss_hit = 0, fill_vld = 0;
  logic [TAG_W-1:0] iss_tag = '0;
  logic [1:0] iss_size = '0;
  logic [2:0] iss_addr = '0;
  logic iss_stall, wb_vld, wb_trap;
  logic [TAG_W-1:0] wb_tag;

  ld_inorder_ret #(.DEPTH(DEPTH), .TAG_W(TAG_W), .HIT_LAT(2)) u_ld_inorder_ret (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_tag(iss_tag),
    .iss_size(iss_size), .iss_sgn(iss_sgn), .iss_addr(iss_addr),
    .iss_hit(iss_hit), .iss_stall(iss_stall), .fill_vld(fill_vld),
    .wb_vld(wb_vld), .wb_trap(wb_trap), .wb_tag(wb_tag));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  // bench model
  int cyc = 0;
  int mcnt = 0;
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic m_trap [DEPTH];
  logic m_miss [DEPTH];
  int   m_rdy  [DEPTH];
  logic m_slow = 0;
  logic e_vld = 0, e_trap = 0, e_stall = 0;
  logic [TAG_W-1:0] e_tag = '0;

  function automatic logic bad_align(input logic [1:0] sz, input logic [2:0] a);
    case (sz)
      2'd0: return 1'b0;
      2'd1: return a[0];
      2'd2: return a[1:0] != 2'b00;
      default: return a != 3'b000;
    endcase
  endfunction

  function automatic int ret_lat(input logic sgn, input logic [1:0] sz, input logic slow);
    return ((sgn && sz != 2'd3) || slow) ? 3 : 2;
  endfunction

  task automatic model_edge();
    logic full, pop;
    cyc++;
    full = (mcnt == DEPTH);
    pop  = (mcnt > 0) && !m_miss[0] && (cyc >= m_rdy[0]);
    if (fill_vld && mcnt > 0 && m_miss[0]) m_miss[0] = 0;
    e_vld  = pop && !m_trap[0];
    e_trap = pop && m_trap[0];
    e_tag  = pop ? m_tag[0] : '0;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_tag[i] = m_tag[i+1]; m_trap[i] = m_trap[i+1];
        m_miss[i] = m_miss[i+1]; m_rdy[i] = m_rdy[i+1];
      end
      mcnt--;
    end
    if (iss_vld && !full) begin
      m_tag[mcnt]  = iss_tag;
      m_trap[mcnt] = bad_align(iss_size, iss_addr);
      m_miss[mcnt] = !iss_hit && !m_trap[mcnt];
      m_rdy[mcnt]  = cyc + ret_lat(iss_sgn, iss_size, m_slow);
      mcnt++;
      m_slow = (iss_sgn && iss_size != 2'd3) || m_slow;
    end else begin
      m_slow = 0;
    end
    e_stall = (mcnt == DEPTH);
  endtask

  task automatic check_outputs();
    checks++;
    if (wb_vld !== e_vld || wb_trap !== e_trap || wb_tag !== e_tag || iss_stall !== e_stall) begin
      fails++;
      $display("FAIL %s cyc %0d: vld/trap/tag/stall actual %b/%b/%0d/%b expected %b/%b/%0d/%b",
               cur_req, cyc, wb_vld, wb_trap, wb_tag, iss_stall, e_vld, e_trap, e_tag, e_stall);
    end
    if (wb_vld && wb_trap) begin
      fails++;
      $display("FAIL R8 cyc %0d: vld and trap both high, actual 1/1 expected at most one", cyc);
    end
  endtask

  task automatic step(input logic v, input logic [TAG_W-1:0] t, input logic [1:0] sz,
                      input logic sg, input logic [2:0] a, input logic h, input logic f);
    @(negedge clk);
    check_outputs();
    iss_vld = v; iss_tag = t; iss_size = sz; iss_sgn = sg; iss_addr = a; iss_hit = h; fill_vld = f;
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 2'd0, 0, 3'd0, 1, 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    checks++;
    if (wb_vld !== 0 || wb_trap !== 0 || iss_stall !== 0 || wb_tag !== 0) begin
      fails++;
      $display("FAIL R1: reset outputs actual %b%b%b expected 000", wb_vld, wb_trap, iss_stall);
    end
    @(posedge clk); model_edge();
    cur_req = "R1"; step(1, 5'd1, 2'd0, 0, 3'd0, 1, 0); idle(4);
    cur_req = "R2"; step(1, 5'd2, 2'd3, 1, 3'd0, 1, 0); idle(4);
    step(1, 5'd3, 2'd2, 0, 3'd4, 1, 0); idle(4);
    cur_req = "R3"; step(1, 5'd4, 2'd0, 1, 3'd3, 1, 0); idle(5);
    step(1, 5'd5, 2'd1, 1, 3'd2, 1, 0); idle(5);
    cur_req = "R4";
    step(1, 5'd6, 2'd2, 1, 3'd0, 1, 0);
    step(1, 5'd7, 2'd3, 0, 3'd0, 1, 0);
    step(1, 5'd8, 2'd0, 0, 3'd1, 1, 0);
    idle(1);
    step(1, 5'd9, 2'd3, 0, 3'd0, 1, 0); idle(5);
    cur_req = "R5";
    step(1, 5'd10, 2'd3, 0, 3'd0, 0, 0);
    step(1, 5'd11, 2'd0, 0, 3'd0, 1, 0);
    step(1, 5'd12, 2'd1, 0, 3'd0, 1, 0);
    idle(6);
    cur_req = "R6";
    step(0, '0, 2'd0, 0, 3'd0, 1, 1); idle(6);
    step(1, 5'd13, 2'd0, 0, 3'd0, 1, 0);
    step(0, '0, 2'd0, 0, 3'd0, 1, 1); idle(4);
    step(0, '0, 2'd0, 0, 3'd0, 1, 1); idle(3);
    cur_req = "R7";
    step(1, 5'd14, 2'd2, 0, 3'd2, 0, 0);
    step(1, 5'd15, 2'd1, 1, 3'd1, 1, 0);
    step(1, 5'd16, 2'd3, 0, 3'd4, 1, 0); idle(6);
    cur_req = "R9";
    for (int i = 0; i < 7; i++) step(1, 5'(20 + i), 2'd3, 0, 3'd0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, '0, 2'd0, 0, 3'd0, 1, 1); idle(2);
    end
    idle(4);
    cur_req = "R5/R6 random";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] sz;
      logic [2:0] a;
      sz = 2'($urandom_range(0, 3));
      a  = ($urandom_range(0, 9) < 8) ? 3'(($urandom_range(0, 7) >> sz) << sz)
                                       : 3'($urandom_range(0, 7));
      step($urandom_range(0, 9) < 7, 5'($urandom_range(0, 31)), sz,
           1'($urandom_range(0, 1)), a, $urandom_range(0, 9) < 8,
           $urandom_range(0, 6) == 0);
    end
    idle(40);
    @(negedge clk);
    check_outputs();
    report();
  end
endmodule